// File: doc/BRIEF.md
# Configurable Bit-Serial CRC Engine

This block computes a cyclic redundancy check one bit per accepted cycle. The divisor polynomial, the register length (3 to 32 bits) and a starting seed arrive on input ports. The block captures them when a message begins. Data enters most significant bit first. The internal register always holds the running remainder of division over GF(2), in which both addition and subtraction are XOR. When the caller marks the final bit, the block presents the check value one cycle later.

The same datapath also verifies messages. A receiver streams the data word and then the received check value, with the check mode input raised on the last bit. A nonzero final remainder raises the mismatch flag. The polynomial is given in compact hex form: the top bit stands for the leading term and the constant term is implied. The block turns that value into feedback taps itself. When a nonzero seed is used, generation and checking must use the same seed.

Top module: `crc_serial_engine`

## Requirements
- R1: The polynomial input uses implicit-plus-one notation. For register width W, bit i of `poly` (i < W-1) stands for term x^(i+1), bit W-1 stands for x^W, and the x^0 term is always present. Bits of `poly` at W and above are ignored. Example: W=12 and poly 0xB41 means x^12+x^10+x^9+x^7+x+1, so one 1 bit shifted into a zero register gives 0x683.
- R2: `width_sel` sets W. Values below 3 act as 3 and values above 32 act as 32. Bits of `crc_value` at position W and above always read zero.
- R3: A cycle with `start` high loads `seed` masked to W. With `bit_valid` low in that cycle, `crc_value` equals the masked seed one cycle later. With `bit_valid` high in that cycle, the bit is processed starting from the seed.
- R4: On each accepted bit, the feedback is the bit XOR register bit W-1. The register shifts left by one within W bits and, if the feedback is 1, is XORed with the tap mask.
- R5: With W=3, poly 0x5 (x^3+x+1) and seed 0, the message 11010011101100 leaves `crc_value` = 3'b100. This equals the remainder of the message with three zero bits appended, divided by 1011.
- R6: With a nonzero seed, an all-zero message gives a nonzero check value.
- R7: `done` pulses high for exactly the one cycle after a bit is accepted with `bit_last` high. `crc_value` holds the final remainder in that cycle. After reset, `crc_value` is 0 and `done` and `mismatch` are 0.
- R8: `mismatch` is high only together with `done`, and only when `check_mode` was high on the last bit and the final remainder is nonzero. Data followed by its own check value, sent MSB first, gives `mismatch` = 0 and `crc_value` = 0.
- R9: The polynomial and width are captured at `start`, and the seed is used only at `start`. Changes to `poly`, `width_sel` or `seed` during a message have no effect.
- R10: While `bit_valid` is low and `start` is low, `bit_in` is ignored and `crc_value` holds.
- R11: 8-bit polynomials 0xA6 and 0x97 and the 32-bit polynomial 0xBA0DC66B generate check values that pass the check mode round trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a message: capture configuration, load seed |
| bit_valid | input | 1 | `bit_in` is accepted this cycle |
| bit_in | input | 1 | Serial data bit, MSB first |
| bit_last | input | 1 | Accepted bit is the final one of the message |
| check_mode | input | 1 | Final bit ends a verification pass (sampled with the last bit) |
| width_sel | input | 6 | Register width W, clamped to 3..32 |
| poly | input | 32 | Divisor in implicit-plus-one notation |
| seed | input | 32 | Initial register value |
| crc_value | output | 32 | Running remainder; check value when `done` is high |
| done | output | 1 | One-cycle pulse after the last bit |
| mismatch | output | 1 | Verification failed (valid with `done`) |

## Verification
The hardest case to reach is a configuration change in the middle of a message while the register sits at a width other than the one on the ports. The register must keep the captured taps and width even though the inputs now describe a different code. The bench scrambles `poly`, `width_sel` and `seed` after the first bit of a message. It then compares the result against a remainder computed from the original settings. A cycle-level model built on polynomial long division also runs beside the design on every clock. Check-mode round trips with random data across three polynomials and both a start-with-data and a start-alone cycle cover the mismatch path and the seed-loading path.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int CRC_MAX_W = 32;
    localparam int CRC_MIN_W = 3;
    localparam int WSEL_W    = $clog2(CRC_MAX_W) + 1;

    typedef logic [CRC_MAX_W-1:0] crc_word_t;
    typedef logic [WSEL_W-1:0]    crc_wsel_t;

    localparam crc_wsel_t WSEL_LO = crc_wsel_t'(CRC_MIN_W);
    localparam crc_wsel_t WSEL_HI = crc_wsel_t'(CRC_MAX_W);

    // Per-message configuration after expansion of the polynomial
    typedef struct packed {
        crc_word_t mask;   // ones in the active register bits
        crc_word_t taps;   // feedback taps, constant term included
    } crc_cfg_t;

    typedef struct packed {
        logic done;
        logic mismatch;
    } crc_status_t;

    function automatic crc_wsel_t clamp_width(crc_wsel_t ws);
        if (ws < WSEL_LO) return WSEL_LO;
        if (ws > WSEL_HI) return WSEL_HI;
        return ws;
    endfunction

    function automatic crc_word_t width_mask(crc_wsel_t w);
        crc_word_t m;
        for (int i = 0; i < CRC_MAX_W; i++) m[i] = (i < int'(w));
        return m;
    endfunction

    // Compact notation: poly bit i is term x^(i+1); x^0 is implied.
    function automatic crc_word_t expand_taps(crc_word_t poly, crc_word_t mask);
        return {poly[CRC_MAX_W-2:0], 1'b1} & mask;
    endfunction

    function automatic crc_cfg_t build_cfg(crc_wsel_t ws, crc_word_t poly);
        crc_cfg_t c;
        c.mask = width_mask(clamp_width(ws));
        c.taps = expand_taps(poly, c.mask);
        return c;
    endfunction

endpackage

// File: rtl/crc_cfg_reg.sv
module crc_cfg_reg
    import crc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  crc_wsel_t width_sel,
    input  crc_word_t poly,
    output crc_cfg_t  cfg_eff
);
    crc_cfg_t cfg_new;
    crc_cfg_t cfg_q;

    assign cfg_new = build_cfg(width_sel, poly);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= build_cfg(WSEL_HI, '0);
        end else if (start) begin
            cfg_q <= cfg_new;
        end
    end

    // The start cycle already uses the new configuration
    assign cfg_eff = start ? cfg_new : cfg_q;

endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] taps,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic [W-1:0] top_bit;
    logic         msb;
    logic         fb;

    // Highest active bit of the mask marks the register MSB
    assign top_bit = mask & ~(mask >> 1);
    assign msb     = |(rem & top_bit);
    assign fb      = din ^ msb;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt[i] = mask[i] & (fb & taps[i]);
        end else begin : g_upper
            assign nxt[i] = mask[i] & (rem[i-1] ^ (fb & taps[i]));
        end
    end

endmodule

// File: rtl/crc_status.sv
module crc_status
    import crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept_last,
    input  logic        check_mode,
    input  logic        rem_nonzero,
    output crc_status_t status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status.done     <= accept_last;
            status.mismatch <= accept_last & check_mode & rem_nonzero;
        end
    end

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        bit_valid,
    input  logic        bit_in,
    input  logic        bit_last,
    input  logic        check_mode,
    input  logic [5:0]  width_sel,
    input  logic [31:0] poly,
    input  logic [31:0] seed,
    output logic [31:0] crc_value,
    output logic        done,
    output logic        mismatch
);
    crc_cfg_t    cfg_eff;
    crc_word_t   rem_q;
    crc_word_t   rem_base;
    crc_word_t   rem_step;
    crc_word_t   rem_d;
    crc_status_t status;

    crc_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .width_sel(crc_wsel_t'(width_sel)),
        .poly     (poly),
        .cfg_eff  (cfg_eff)
    );

    assign rem_base = start ? (seed & cfg_eff.mask) : rem_q;

    crc_bit_step #(.W(CRC_MAX_W)) u_step (
        .rem (rem_base),
        .mask(cfg_eff.mask),
        .taps(cfg_eff.taps),
        .din (bit_in),
        .nxt (rem_step)
    );

    assign rem_d = bit_valid ? rem_step : rem_base;

    always_ff @(posedge clk) begin
        if (rst) rem_q <= '0;
        else     rem_q <= rem_d;
    end

    crc_status u_status (
        .clk        (clk),
        .rst        (rst),
        .accept_last(bit_valid & bit_last),
        .check_mode (check_mode),
        .rem_nonzero(|rem_step),
        .status     (status)
    );

    assign crc_value = rem_q;
    assign done      = status.done;
    assign mismatch  = status.mismatch;

endmodule

// File: rtl/crc_serial_engine_checker.sv
module crc_serial_engine_checker
    import crc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        bit_valid,
    input logic        bit_last,
    input logic [5:0]  width_sel,
    input logic [31:0] seed,
    input logic [31:0] crc_value,
    input logic        done,
    input logic        mismatch
);
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bit_valid && bit_last));

    assert_mismatch_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> done);

    assert_mismatch_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> (crc_value != 32'd0));

    assert_seed_load_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !bit_valid) |=>
            (crc_value == ($past(seed) & width_mask(clamp_width(crc_wsel_t'($past(width_sel)))))));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!start && !bit_valid) |=> $stable(crc_value));

endmodule

bind crc_serial_engine crc_serial_engine_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .bit_valid(bit_valid),
    .bit_last (bit_last),
    .width_sel(width_sel),
    .seed     (seed),
    .crc_value(crc_value),
    .done     (done),
    .mismatch (mismatch)
);

// File: tb/crc_serial_engine_bench.sv
module crc_serial_engine_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, bit_valid, bit_in, bit_last, check_mode;
    logic [5:0]  width_sel;
    logic [31:0] poly, seed;
    logic [31:0] crc_value;
    logic        done, mismatch;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    crc_serial_engine u_crc_serial_engine (
        .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid),
        .bit_in(bit_in), .bit_last(bit_last), .check_mode(check_mode),
        .width_sel(width_sel), .poly(poly), .seed(seed),
        .crc_value(crc_value), .done(done), .mismatch(mismatch)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clampw(input logic [5:0] ws);
        if (ws < 6'd3)  return 3;
        if (ws > 6'd32) return 32;
        return int'(ws);
    endfunction

    // One step of long division: bring down a bit, subtract divisor if the
    // leading term appears.
    function automatic logic [63:0] div_step(input logic [63:0] r, input int w,
                                             input logic [31:0] p, input logic b);
        logic [63:0] g;
        logic [63:0] t;
        g = ((64'(p) << 1) | 64'd1 | (64'd1 << w)) & ((64'd1 << (w + 1)) - 64'd1);
        t = (r << 1) ^ (64'(b) << w);
        if (t[w]) t = t ^ g;
        return t;
    endfunction

    function automatic logic [63:0] ref_crc(input logic [5:0] ws, input logic [31:0] p,
                                            input logic [31:0] s, input bit q[$]);
        int w;
        logic [63:0] r;
        w = clampw(ws);
        r = 64'(s) & ((64'd1 << w) - 64'd1);
        foreach (q[i]) r = div_step(r, w, p, q[i]);
        return r;
    endfunction

    // Cycle-level reference model
    int          m_w;
    logic [31:0] m_poly;
    logic [63:0] m_rem;
    logic [31:0] e_crc;
    logic        e_done, e_mis;

    always @(posedge clk) begin
        if (rst) begin
            m_w = 32; m_poly = '0; m_rem = '0;
            e_crc = '0; e_done = 1'b0; e_mis = 1'b0;
        end else begin
            if (start) begin
                m_w    = clampw(width_sel);
                m_poly = poly;
                m_rem  = 64'(seed) & ((64'd1 << m_w) - 64'd1);
            end
            e_done = bit_valid && bit_last;
            e_mis  = 1'b0;
            if (bit_valid) begin
                m_rem = div_step(m_rem, m_w, m_poly, bit_in);
                if (bit_last && check_mode && m_rem != 64'd0) e_mis = 1'b1;
            end
            e_crc = m_rem[31:0];
        end
    end

    always @(negedge clk) begin
        if (!rst)
            check({done, mismatch, crc_value} == {e_done, e_mis, e_crc},
                  "R4 R7 R8 per-cycle model", {30'd0, done, mismatch, crc_value},
                  {30'd0, e_done, e_mis, e_crc});
    end

    task automatic go_idle();
        start = 1'b0; bit_valid = 1'b0; bit_last = 1'b0; bit_in = 1'b0;
    endtask

    task automatic send(input logic [5:0] ws, input logic [31:0] p, input logic [31:0] s,
                        input logic chk, input bit q[$], input bit scramble);
        foreach (q[i]) begin
            @(negedge clk);
            start      = (i == 0);
            bit_valid  = 1'b1;
            bit_in     = q[i];
            bit_last   = (i == q.size() - 1);
            check_mode = chk;
            if (scramble && i > 0) begin
                width_sel = 6'($urandom_range(0, 40));
                poly      = $urandom;
                seed      = $urandom;
            end else begin
                width_sel = ws; poly = p; seed = s;
            end
        end
        @(negedge clk);
        go_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit msg[$] = '{1,1,0,1,0,0,1,1,1,0,1,1,0,0};
        bit q[$];
        logic [31:0] held;
        logic [63:0] c;

        rst = 1'b1; go_idle(); check_mode = 1'b0;
        width_sel = 6'd8; poly = '0; seed = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(crc_value == 32'd0 && !done && !mismatch, "R7 reset state",
              {31'd0, done, crc_value}, 64'd0);

        // R1: tap expansion of 0xB41 at width 12
        q = {}; q.push_back(1'b1);
        send(6'd12, 32'hB41, 32'd0, 1'b0, q, 1'b0);
        check(crc_value == 32'h683, "R1 tap expansion", 64'(crc_value), 64'h683);

        // R5: worked division example
        send(6'd3, 32'h5, 32'd0, 1'b0, msg, 1'b0);
        check(crc_value == 32'h4, "R5 remainder 100", 64'(crc_value), 64'h4);
        check(done == 1'b1, "R7 done after last", 64'(done), 64'd1);

        // R8: data plus its own check value verifies clean
        q = msg; q.push_back(1'b1); q.push_back(1'b0); q.push_back(1'b0);
        send(6'd3, 32'h5, 32'd0, 1'b1, q, 1'b0);
        check(mismatch == 1'b0 && crc_value == 32'd0, "R8 clean verify",
              {31'd0, mismatch, crc_value}, 64'd0);
        q[4] = ~q[4];
        send(6'd3, 32'h5, 32'd0, 1'b1, q, 1'b0);
        check(mismatch == 1'b1 && done == 1'b1, "R8 corrupted verify",
              64'({done, mismatch}), 64'd3);

        // R6: nonzero seed, all-zero data
        q = {};
        for (int i = 0; i < 16; i++) q.push_back(1'b0);
        send(6'd8, 32'h97, 32'hFF, 1'b0, q, 1'b0);
        c = ref_crc(6'd8, 32'h97, 32'hFF, q);
        check(crc_value != 32'd0 && 64'(crc_value) == c, "R6 seeded zero data",
              64'(crc_value), c);

        // R3: start alone loads masked seed
        @(negedge clk); start = 1'b1; width_sel = 6'd16; seed = 32'h1234ABCD;
        @(negedge clk); start = 1'b0;
        check(crc_value == 32'h0000ABCD, "R3 seed load", 64'(crc_value), 64'hABCD);

        // R2: width clamping and masking of upper bits
        @(negedge clk); start = 1'b1; width_sel = 6'd40; seed = 32'hFFFFFFFF;
        @(negedge clk); start = 1'b0;
        check(crc_value == 32'hFFFFFFFF, "R2 width above 32 clamps", 64'(crc_value), 64'hFFFFFFFF);
        @(negedge clk); start = 1'b1; width_sel = 6'd1;
        @(negedge clk); start = 1'b0;
        check(crc_value == 32'h7, "R2 width below 3 clamps", 64'(crc_value), 64'h7);
        @(negedge clk); start = 1'b1; width_sel = 6'd8;
        @(negedge clk); start = 1'b0;
        check(crc_value == 32'hFF, "R2 upper bits zero", 64'(crc_value), 64'hFF);

        // R10: bit_in ignored without bit_valid
        held = crc_value;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); bit_in = i[0];
        end
        @(negedge clk);
        check(crc_value == held, "R10 idle hold", 64'(crc_value), 64'(held));
        go_idle();

        // R9: configuration changes mid-message are ignored
        q = {};
        for (int i = 0; i < 24; i++) q.push_back(bit'($urandom_range(0, 1)));
        send(6'd16, 32'h8810, 32'hBEEF, 1'b0, q, 1'b1);
        c = ref_crc(6'd16, 32'h8810, 32'hBEEF, q);
        check(64'(crc_value) == c, "R9 captured configuration", 64'(crc_value), c);

        // R11: round trips with the named polynomials
        for (int k = 0; k < 3; k++) begin
            logic [5:0]  ws;
            logic [31:0] p;
            ws = (k == 2) ? 6'd32 : 6'd8;
            p  = (k == 0) ? 32'hA6 : (k == 1) ? 32'h97 : 32'hBA0DC66B;
            for (int rep = 0; rep < 4; rep++) begin
                q = {};
                for (int i = 0; i < 40; i++) q.push_back(bit'($urandom_range(0, 1)));
                send(ws, p, 32'hFFFFFFFF, 1'b0, q, 1'b0);
                c = ref_crc(ws, p, 32'hFFFFFFFF, q);
                check(64'(crc_value) == c, "R11 generate", 64'(crc_value), c);
                for (int i = int'(ws) - 1; i >= 0; i--) q.push_back(c[i]);
                send(ws, p, 32'hFFFFFFFF, 1'b1, q, 1'b0);
                check(!mismatch && done && crc_value == 32'd0, "R11 verify round trip",
                      {31'd0, mismatch, crc_value}, 64'd0);
            end
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule